// File: doc/BRIEF.md
# Seven-Stage Pipeline Bypass and Squash Controller

This block settles data and control hazards for an in-order pipeline with seven stages, in this order: two fetch stages, decode, execute, two memory stages and writeback. Each source register of the instruction in execute is compared with the destination register of each of the three older instructions in the memory and writeback stages. When one of them matches, the block sends that instruction's result straight to the execute operand. A program can therefore place dependent instructions next to each other. Without the bypass, the program would need three padding instructions between them, because a result in the first memory stage takes three more cycles to reach the register file.

The block also owns the two slot registers that feed decode and execute. A jump, or a branch that is taken, resolves in execute and raises a flush. The flush turns both younger slots into bubbles. A bubble carries the canonical no-op word 0x00000013 with its nop flag set. A fetch marked as a no-op, or a fetch cycle in which the instruction bus stalls, also enters decode as such a bubble. An external stall input freezes both slots.

Top module: `fwd_flush_ctrl`

## Requirements
- R1: While reset is high, and after it is released until the first advance, both slots hold instruction 0x00000013 with nop flag 1.
- R2: On a clock edge with no reset, no flush and no stall, the decode slot takes fetchWord with nop flag 0 when neither fetchNop nor busStall is set. In the same edge, the execute slot takes the previous decode slot contents.
- R3: On an advancing edge with fetchNop or busStall high, the decode slot takes 0x00000013 with nop flag 1.
- R4: flush is high in the same cycle that exJump or exTaken is high. On the next edge both slots become 0x00000013 with nop flag 1, whatever the value of stall.
- R5: On an edge with stall high and flush low, both slots keep their contents.
- R6: Select code 1 means the first memory stage, 2 the second memory stage and 3 writeback. When an operand's source register matches a valid producer, that operand equals the producer's result and its select shows the producer's code.
- R7: When several valid producers match, the first memory stage wins over the second, and the second wins over writeback.
- R8: A producer whose nop flag is 1, or whose destination is register 0, is never bypassed. A source register of 0 therefore always reads the register file.
- R9: When no valid producer matches, the select is 0 and the operand equals the register-file read value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Freeze the decode and execute slots |
| fetchWord | input | 32 | Instruction word returned by the fetch bus |
| fetchNop | input | 1 | The incoming fetch slot is a bubble |
| busStall | input | 1 | The fetch bus did not deliver a word this cycle |
| exRs1 | input | 5 | First source register of the execute instruction |
| exRs2 | input | 5 | Second source register of the execute instruction |
| rfData1 | input | 32 | Register-file read value for exRs1 |
| rfData2 | input | 32 | Register-file read value for exRs2 |
| me1Rd | input | 5 | Destination register of the first memory stage |
| me1Nop | input | 1 | The first memory stage holds a bubble |
| me1Result | input | 32 | Result held in the first memory stage |
| me2Rd | input | 5 | Destination register of the second memory stage |
| me2Nop | input | 1 | The second memory stage holds a bubble |
| me2Result | input | 32 | Result held in the second memory stage |
| wbRd | input | 5 | Destination register of the writeback stage |
| wbNop | input | 1 | The writeback stage holds a bubble |
| wbResult | input | 32 | Result held in the writeback stage |
| exJump | input | 1 | The execute instruction is a jump |
| exTaken | input | 1 | The execute instruction is a taken branch |
| flush | output | 1 | Squash the younger slots |
| decInstr | output | 32 | Instruction word of the decode slot |
| decNop | output | 1 | Nop flag of the decode slot |
| exInstr | output | 32 | Instruction word of the execute slot |
| exNop | output | 1 | Nop flag of the execute slot |
| opA | output | 32 | Bypassed first operand |
| opB | output | 32 | Bypassed second operand |
| selA | output | 2 | Source of opA: 0 register file, 1 first memory stage, 2 second memory stage, 3 writeback |
| selB | output | 2 | Source of opB, with the same codes as selA |

## Verification
The bench sets up producers with the same destination in two or three stages at once. A design with the wrong priority order would hand an older value to execute. It also marks the youngest matching producer as a bubble, or gives it destination 0. A design that ignored the nop flag or the x0 rule would bypass garbage, and a read of register 0 would stop returning the register-file value. Flush is raised together with stall and together with busStall. A design that let stall win over flush would keep a squashed instruction alive. A design that forwarded the raw fetch word during a bus stall would put a stale word into decode.

// File: rtl/fwd_flush_pkg.sv
package fwd_flush_pkg;
  // operand source codes; the order is the bypass priority
  typedef enum logic [1:0] {
    SEL_RF  = 2'd0,
    SEL_ME1 = 2'd1,
    SEL_ME2 = 2'd2,
    SEL_WB  = 2'd3
  } fwdSel_t;

  // strobes from control to datapath
  typedef struct packed {
    fwdSel_t selA;
    fwdSel_t selB;
    logic    squash;
    logic    advance;
  } strobes_t;

  localparam int NUM_PROD = 3;
  localparam int NUM_OPS  = 2;
  localparam logic [31:0] NOP_WORD32 = 32'h0000_0013;
endpackage

// File: rtl/fwd_ctrl.sv
module fwd_ctrl
  import fwd_flush_pkg::*;
#(
  parameter int REG_BITS = 5
) (
  input  logic [REG_BITS-1:0] exRs1,
  input  logic [REG_BITS-1:0] exRs2,
  input  logic [REG_BITS-1:0] me1Rd,
  input  logic                me1Nop,
  input  logic [REG_BITS-1:0] me2Rd,
  input  logic                me2Nop,
  input  logic [REG_BITS-1:0] wbRd,
  input  logic                wbNop,
  input  logic                exJump,
  input  logic                exTaken,
  input  logic                stall,
  output strobes_t            strobes
);
  logic [NUM_PROD-1:0][REG_BITS-1:0] prodRd;
  logic [NUM_PROD-1:0]               prodLive;
  logic [NUM_OPS-1:0][REG_BITS-1:0]  srcReg;
  fwdSel_t                           opSel [NUM_OPS];

  assign prodRd   = {wbRd, me2Rd, me1Rd};
  assign prodLive = {~wbNop  && (wbRd  != '0),
                     ~me2Nop && (me2Rd != '0),
                     ~me1Nop && (me1Rd != '0)};
  assign srcReg   = {exRs2, exRs1};

  for (genvar op = 0; op < NUM_OPS; op++) begin : g_op
    logic [NUM_PROD-1:0] hit;
    for (genvar p = 0; p < NUM_PROD; p++) begin : g_prod
      assign hit[p] = prodLive[p] && (prodRd[p] == srcReg[op]);
    end
    always_comb begin
      // youngest producer (lowest index) wins
      if (hit[0])      opSel[op] = SEL_ME1;
      else if (hit[1]) opSel[op] = SEL_ME2;
      else if (hit[2]) opSel[op] = SEL_WB;
      else             opSel[op] = SEL_RF;
    end
  end

  always_comb begin
    strobes.selA    = opSel[0];
    strobes.selB    = opSel[1];
    strobes.squash  = exJump | exTaken;
    strobes.advance = ~stall;
  end
endmodule

// File: rtl/fwd_datapath.sv
module fwd_datapath
  import fwd_flush_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  strobes_t        strobes,
  input  logic [XLEN-1:0] fetchWord,
  input  logic            fetchNop,
  input  logic            busStall,
  input  logic [XLEN-1:0] rfData1,
  input  logic [XLEN-1:0] rfData2,
  input  logic [XLEN-1:0] me1Result,
  input  logic [XLEN-1:0] me2Result,
  input  logic [XLEN-1:0] wbResult,
  output logic [XLEN-1:0] decInstr,
  output logic            decNop,
  output logic [XLEN-1:0] exInstr,
  output logic            exNop,
  output logic [XLEN-1:0] opA,
  output logic [XLEN-1:0] opB
);
  localparam logic [XLEN-1:0] NOP_WORD = XLEN'(NOP_WORD32);

  logic [NUM_OPS-1:0][XLEN-1:0] rfVals;
  logic [NUM_OPS-1:0][XLEN-1:0] opVals;
  fwdSel_t                      sels [NUM_OPS];

  assign rfVals  = {rfData2, rfData1};
  assign sels[0] = strobes.selA;
  assign sels[1] = strobes.selB;

  for (genvar op = 0; op < NUM_OPS; op++) begin : g_mux
    always_comb begin
      unique case (sels[op])
        SEL_ME1: opVals[op] = me1Result;
        SEL_ME2: opVals[op] = me2Result;
        SEL_WB:  opVals[op] = wbResult;
        default: opVals[op] = rfVals[op];
      endcase
    end
  end

  assign opA = opVals[0];
  assign opB = opVals[1];

  logic fetchBubble;
  assign fetchBubble = fetchNop | busStall;

  always_ff @(posedge clk) begin
    if (rst || strobes.squash) begin
      decInstr <= NOP_WORD;
      decNop   <= 1'b1;
      exInstr  <= NOP_WORD;
      exNop    <= 1'b1;
    end else if (strobes.advance) begin
      exInstr  <= decInstr;
      exNop    <= decNop;
      decInstr <= fetchBubble ? NOP_WORD : fetchWord;
      decNop   <= fetchBubble;
    end
  end
endmodule

// File: rtl/fwd_flush_ctrl.sv
module fwd_flush_ctrl
  import fwd_flush_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int REG_BITS = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                stall,
  input  logic [XLEN-1:0]     fetchWord,
  input  logic                fetchNop,
  input  logic                busStall,
  input  logic [REG_BITS-1:0] exRs1,
  input  logic [REG_BITS-1:0] exRs2,
  input  logic [XLEN-1:0]     rfData1,
  input  logic [XLEN-1:0]     rfData2,
  input  logic [REG_BITS-1:0] me1Rd,
  input  logic                me1Nop,
  input  logic [XLEN-1:0]     me1Result,
  input  logic [REG_BITS-1:0] me2Rd,
  input  logic                me2Nop,
  input  logic [XLEN-1:0]     me2Result,
  input  logic [REG_BITS-1:0] wbRd,
  input  logic                wbNop,
  input  logic [XLEN-1:0]     wbResult,
  input  logic                exJump,
  input  logic                exTaken,
  output logic                flush,
  output logic [XLEN-1:0]     decInstr,
  output logic                decNop,
  output logic [XLEN-1:0]     exInstr,
  output logic                exNop,
  output logic [XLEN-1:0]     opA,
  output logic [XLEN-1:0]     opB,
  output logic [1:0]          selA,
  output logic [1:0]          selB
);
  strobes_t strobes;

  fwd_ctrl #(.REG_BITS(REG_BITS)) u_ctrl (
    .exRs1(exRs1), .exRs2(exRs2),
    .me1Rd(me1Rd), .me1Nop(me1Nop),
    .me2Rd(me2Rd), .me2Nop(me2Nop),
    .wbRd(wbRd),   .wbNop(wbNop),
    .exJump(exJump), .exTaken(exTaken),
    .stall(stall),
    .strobes(strobes)
  );

  fwd_datapath #(.XLEN(XLEN)) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes),
    .fetchWord(fetchWord), .fetchNop(fetchNop), .busStall(busStall),
    .rfData1(rfData1), .rfData2(rfData2),
    .me1Result(me1Result), .me2Result(me2Result), .wbResult(wbResult),
    .decInstr(decInstr), .decNop(decNop),
    .exInstr(exInstr), .exNop(exNop),
    .opA(opA), .opB(opB)
  );

  assign flush = strobes.squash;
  assign selA  = strobes.selA;
  assign selB  = strobes.selB;
endmodule

// File: rtl/fwd_flush_chk.sv
module fwd_flush_chk #(
  parameter int XLEN     = 32,
  parameter int REG_BITS = 5
) (
  input logic                clk,
  input logic                rst,
  input logic                stall,
  input logic [REG_BITS-1:0] exRs1,
  input logic [XLEN-1:0]     me1Result,
  input logic                me1Nop,
  input logic                flush,
  input logic [XLEN-1:0]     decInstr,
  input logic                decNop,
  input logic [XLEN-1:0]     exInstr,
  input logic                exNop,
  input logic [XLEN-1:0]     opA,
  input logic [1:0]          selA
);
  localparam logic [XLEN-1:0] BUBBLE = XLEN'(32'h0000_0013);

  // R4
  squash_clears_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> (decNop && exNop && decInstr == BUBBLE && exInstr == BUBBLE));

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (stall && !flush) |=> ($stable(decInstr) && $stable(exInstr) && $stable(decNop) && $stable(exNop)));

  // R2
  slot_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (!stall && !flush) |=> (exInstr == $past(decInstr) && exNop == $past(decNop)));

  // R3
  bubble_word_chk: assert property (@(posedge clk) disable iff (rst)
    decNop |-> decInstr == BUBBLE);

  // R8
  zero_src_chk: assert property (@(posedge clk) disable iff (rst)
    (exRs1 == '0) |-> selA == 2'd0);

  // R6
  me1_value_chk: assert property (@(posedge clk) disable iff (rst)
    (selA == 2'd1) |-> (opA == me1Result && !me1Nop));
endmodule

bind fwd_flush_ctrl fwd_flush_chk #(.XLEN(XLEN), .REG_BITS(REG_BITS)) u_chk (
  .clk(clk), .rst(rst), .stall(stall), .exRs1(exRs1),
  .me1Result(me1Result), .me1Nop(me1Nop), .flush(flush),
  .decInstr(decInstr), .decNop(decNop), .exInstr(exInstr), .exNop(exNop),
  .opA(opA), .selA(selA)
);

// File: tb/sim_fwd_flush_ctrl.sv
`timescale 1ns/1ps
module sim_fwd_flush_ctrl;
  localparam logic [31:0] NOPW = 32'h0000_0013;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst, stall, fetchNop, busStall, me1Nop, me2Nop, wbNop, exJump, exTaken;
  logic [31:0] fetchWord, rfData1, rfData2, me1Result, me2Result, wbResult;
  logic [4:0]  exRs1, exRs2, me1Rd, me2Rd, wbRd;
  logic        flush, decNop, exNop;
  logic [31:0] decInstr, exInstr, opA, opB;
  logic [1:0]  selA, selB;

  fwd_flush_ctrl u0 (.*);

  int checks = 0;
  int fails  = 0;

  // reference state of the two slots
  logic [31:0] mDecI, mExI;
  logic        mDecN, mExN;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [1:0] expSel(logic [4:0] rs);
    if (rs == 0) return 2'd0;
    if (!me1Nop && me1Rd == rs) return 2'd1;
    if (!me2Nop && me2Rd == rs) return 2'd2;
    if (!wbNop  && wbRd  == rs) return 2'd3;
    return 2'd0;
  endfunction

  function automatic string selTag(logic [4:0] rs, logic [1:0] s);
    int n;
    n = 0;
    if (s == 2'd0) begin
      if ((me1Rd == rs) || (me2Rd == rs) || (wbRd == rs)) return "R8";
      return "R9";
    end
    if (me1Rd == rs && !me1Nop && rs != 0) n++;
    if (me2Rd == rs && !me2Nop && rs != 0) n++;
    if (wbRd  == rs && !wbNop  && rs != 0) n++;
    return (n > 1) ? "R7" : "R6";
  endfunction

  function automatic logic [31:0] expVal(logic [1:0] s, logic [31:0] rf);
    case (s)
      2'd1: return me1Result;
      2'd2: return me2Result;
      2'd3: return wbResult;
      default: return rf;
    endcase
  endfunction

  // compare mid-cycle, then advance the model on the edge
  task automatic step();
    logic [1:0] sa, sb;
    #2;
    sa = expSel(exRs1);
    sb = expSel(exRs2);
    chk("R4", "flush", {31'd0, flush}, {31'd0, exJump | exTaken});
    chk(selTag(exRs1, sa), "selA", {30'd0, selA}, {30'd0, sa});
    chk(selTag(exRs1, sa), "opA", opA, expVal(sa, rfData1));
    chk(selTag(exRs2, sb), "selB", {30'd0, selB}, {30'd0, sb});
    chk(selTag(exRs2, sb), "opB", opB, expVal(sb, rfData2));
    chk("R2", "decInstr", decInstr, mDecI);
    chk("R3", "decNop", {31'd0, decNop}, {31'd0, mDecN});
    chk("R2", "exInstr", exInstr, mExI);
    chk("R5", "exNop", {31'd0, exNop}, {31'd0, mExN});
    @(posedge clk);
    if (rst || exJump || exTaken) begin
      mDecI = NOPW; mDecN = 1'b1; mExI = NOPW; mExN = 1'b1;
    end else if (!stall) begin
      mExI = mDecI; mExN = mDecN;
      if (fetchNop || busStall) begin mDecI = NOPW; mDecN = 1'b1; end
      else begin mDecI = fetchWord; mDecN = 1'b0; end
    end
    @(negedge clk);
  endtask

  task automatic quiet();
    stall = 0; fetchNop = 0; busStall = 0; exJump = 0; exTaken = 0;
    me1Nop = 1; me2Nop = 1; wbNop = 1;
    me1Rd = 0; me2Rd = 0; wbRd = 0; exRs1 = 0; exRs2 = 0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #(8 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    quiet();
    rst = 1; fetchWord = 32'hdead_0001;
    rfData1 = 32'h1111_1111; rfData2 = 32'h2222_2222;
    me1Result = 32'hAAAA_0001; me2Result = 32'hBBBB_0002; wbResult = 32'hCCCC_0003;
    mDecI = NOPW; mDecN = 1; mExI = NOPW; mExN = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1", "decInstr", decInstr, NOPW);
    chk("R1", "decNop", {31'd0, decNop}, 32'd1);
    chk("R1", "exInstr", exInstr, NOPW);
    chk("R1", "exNop", {31'd0, exNop}, 32'd1);
    step();
    rst = 0;

    // R2 normal advance
    fetchWord = 32'h0050_0093; step();
    fetchWord = 32'h0010_8113; step();
    // R3 bus stall and nop fetch
    busStall = 1; fetchWord = 32'h1234_5678; step();
    busStall = 0; fetchNop = 1; step();
    fetchNop = 0; fetchWord = 32'h00a0_0513; step();
    // R5 stall holds
    stall = 1; fetchWord = 32'h0bad_0bad; step(); step();
    // R4 flush wins over stall
    exJump = 1; step();
    stall = 0; exJump = 0; fetchWord = 32'h0000_1111; step();
    exTaken = 1; busStall = 1; step();
    exTaken = 0; busStall = 0; step();

    // R7 all three match
    exRs1 = 5; exRs2 = 5;
    me1Rd = 5; me2Rd = 5; wbRd = 5; me1Nop = 0; me2Nop = 0; wbNop = 0; step();
    // R7 ME2 over WB when ME1 is a bubble; R8 bubble producer skipped
    me1Nop = 1; step();
    // R6 writeback only
    me2Nop = 1; step();
    // R8 destination x0 and source x0
    wbRd = 0; exRs1 = 0; exRs2 = 0; me1Rd = 0; me1Nop = 0; step();
    // R9 no match
    quiet(); exRs1 = 7; exRs2 = 9; me1Nop = 0; me1Rd = 3; step();
    // R6 separate operands from different stages
    me1Rd = 7; me2Rd = 9; me2Nop = 0; step();

    // mixed traffic
    for (int i = 0; i < 600; i++) begin
      exRs1 = 5'($urandom_range(0, 3));
      exRs2 = 5'($urandom_range(0, 3));
      me1Rd = 5'($urandom_range(0, 3));
      me2Rd = 5'($urandom_range(0, 3));
      wbRd  = 5'($urandom_range(0, 3));
      me1Nop = ($urandom_range(0, 3) == 0);
      me2Nop = ($urandom_range(0, 3) == 0);
      wbNop  = ($urandom_range(0, 3) == 0);
      me1Result = $urandom; me2Result = $urandom; wbResult = $urandom;
      rfData1 = $urandom; rfData2 = $urandom;
      fetchWord = $urandom;
      fetchNop = ($urandom_range(0, 7) == 0);
      busStall = ($urandom_range(0, 6) == 0);
      stall    = ($urandom_range(0, 6) == 0);
      exJump   = ($urandom_range(0, 11) == 0);
      exTaken  = ($urandom_range(0, 11) == 0);
      step();
    end

    summary();
    $finish;
  end
endmodule